// File: doc/BRIEF.md
# Real-Time Clock Event Status and Interrupt Controller

This block owns the status/control word of a real-time clock. Event sources are the one-second tick, five calendar and stopwatch alarm match pulses, and an internal millisecond periodic timer. Each source has a sticky event flag and a matching enable bit. Software reads and writes the word over a simple register bus. The event flags clear when a 1 is written to them. The enable bits are plain read/write, so software can change enables without losing pending events.

Two interrupt lines leave the block. One is raised by the one-second event and the other by every alarm-type event, the periodic timer included. The periodic timer counts millisecond strobes against a programmable interval. It has a count-enable bit that is separate from its interrupt enable. Calendar counting, the prescaler and the stopwatch counters are outside the block.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag, every enable, the count-enable bit and the interval register are zero, and both interrupt lines are low.
- R2: The status word is at address 0x08. Flags are at bits 0 (main alarm), 1 (one-second), 4 (alarm 1), 6 (alarm 2), 8 (stopwatch 1), 10 (stopwatch 2) and 13 (periodic). Their enables are at bits 2, 3, 5, 7, 9, 11 and 14. Bit 15 is the periodic count enable. All other bits read 0. The interval register is at address 0x38 and uses its low 10 bits. Any other address reads 0, and writes to it change nothing.
- R3: A pulse on `sec_tick` or on `alm_hit[k]` sets its flag, and the flag stays set until it is cleared. `alm_hit` bit 0 is the main alarm, 1 is alarm 1, 2 is alarm 2, 3 is stopwatch 1 and 4 is stopwatch 2.
- R4: Writing 1 to a flag bit of the status word clears that flag, and writing 0 leaves it unchanged. Enable bits take the written value.
- R5: When an event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R6: `irq_sec` is high exactly when the one-second flag and its enable (bit 3) are both set. The flag is still set when the enable is 0.
- R7: `irq_alarm` is high when any alarm-type flag is set together with its own enable. The pairs are 0/2, 4/5, 6/7, 8/9, 10/11 and 13/14.
- R8: The periodic counter advances on `ms_tick` only while bit 15 is set. On the tick that brings the count to the interval it sets bit 13 and restarts from zero. While bit 15 is 0 the counter is held at zero.
- R9: An interval of zero never produces a periodic event. Intervals up to 1000 ticks are honoured exactly.
- R10: Read data is registered. It appears in the cycle after `bus_rd` and reflects the state before that edge. It holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sec_tick | input | 1 | One-second strobe |
| ms_tick | input | 1 | Millisecond strobe |
| alm_hit | input | 5 | Alarm and stopwatch match pulses |
| irq_sec | output | 1 | One-second interrupt |
| irq_alarm | output | 1 | Combined alarm-type interrupt |

## Verification
The flags are driven in several ways: single events against closed enables, events followed by an enable write, and writes of 0 to a pending flag. These show whether the sticky flag, the gating enable and the write-1-clear path are independent of each other. A clear write is made in the same cycle as a stopwatch event and again as a periodic event, which separates set-wins from clear-wins. The periodic timer runs with interval 3, interval 1, interval 0, the maximum of 1000, and with the count enable off. These runs catch off-by-one counting, a counter that does not restart, and missing gating.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int NFLAG      = 7;
   localparam int STAT_W     = 16;
   localparam int SEC_IDX    = 1;
   localparam int PER_IDX    = 6;
   localparam int CNT_EN_POS = 15;
   // flag index -> status bit of the flag and of its enable
   localparam int FLAG_POS [NFLAG] = '{0, 1, 4, 6, 8, 10, 13};
   localparam int EN_POS   [NFLAG] = '{2, 3, 5, 7, 9, 11, 14};
   // every flag except the one-second flag feeds the alarm line
   localparam logic [NFLAG-1:0] ALM_MASK = 7'b111_1101;
endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end
endmodule

// File: rtl/rtc_pit.sv
module rtc_pit #(
   parameter int PER_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             cnt_en,
   input  logic [PER_W-1:0] ivl,
   output logic             evt
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W:0]   cnt_inc;
   logic             ivl_live;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign ivl_live = (ivl != '0);
   assign evt      = ms_tick && cnt_en && ivl_live && (cnt_inc >= {1'b0, ivl});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!cnt_en)            cnt_q <= '0;
      else if (ms_tick && evt)     cnt_q <= '0;
      else if (ms_tick && ivl_live) cnt_q <= cnt_inc[PER_W-1:0];
   end
endmodule

// File: rtl/rtc_reg_rd.sv
module rtc_reg_rd #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 8,
   parameter int                PER_W    = 10,
   parameter logic [ADDR_W-1:0] STAT_OFF = 8'h08,
   parameter logic [ADDR_W-1:0] PER_OFF  = 8'h38,
   parameter bit                RD_REG   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [rtc_irq_pkg::STAT_W-1:0] stat,
   input  logic [PER_W-1:0]              ivl,
   output logic [DATA_W-1:0]             rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == STAT_OFF)     sel[rtc_irq_pkg::STAT_W-1:0] = stat;
      else if (addr == PER_OFF) sel[PER_W-1:0] = ivl;
   end

   generate
      if (RD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  rdata <= '0;
            else if (rd) rdata <= sel;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata = rd ? sel : '0;
      end
   endgenerate
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 8,
   parameter int                PER_W    = 10,
   parameter logic [ADDR_W-1:0] STAT_OFF = 8'h08,
   parameter logic [ADDR_W-1:0] PER_OFF  = 8'h38,
   parameter bit                RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sec_tick,
   input  logic              ms_tick,
   input  logic [4:0]        alm_hit,
   output logic              irq_sec,
   output logic              irq_alarm
);
   import rtc_irq_pkg::*;

   generate
      if (DATA_W <= STAT_W) begin : g_bad_data
         $error("rtc_irq_ctrl: DATA_W must exceed the status word width");
      end
      if (PER_W < 10 || PER_W > STAT_W) begin : g_bad_per
         $error("rtc_irq_ctrl: PER_W must hold 1000 and fit the word");
      end
      if (STAT_OFF == PER_OFF) begin : g_bad_map
         $error("rtc_irq_ctrl: register offsets collide");
      end
   endgenerate

   logic              stat_wr, ivl_wr;
   logic [NFLAG-1:0]  flag_q, en_q, evt_all;
   logic              cnt_en_q;
   logic [PER_W-1:0]  ivl_q;
   logic              pit_evt;
   logic [STAT_W-1:0] stat;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:STAT_W];
   assign stat_wr = bus_wr && (bus_addr == STAT_OFF);
   assign ivl_wr  = bus_wr && (bus_addr == PER_OFF);
   assign evt_all = {pit_evt, alm_hit[4:1], sec_tick, alm_hit[0]};

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         rtc_evt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_all[i]),
            .clr_i (stat_wr && bus_wdata[FLAG_POS[i]]),
            .q     (flag_q[i])
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en_q[i] <= 1'b0;
            else if (stat_wr) en_q[i] <= bus_wdata[EN_POS[i]];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_en_q <= 1'b0;
         ivl_q    <= '0;
      end else begin
         if (stat_wr) cnt_en_q <= bus_wdata[CNT_EN_POS];
         if (ivl_wr)  ivl_q    <= bus_wdata[PER_W-1:0];
      end
   end

   rtc_pit #(.PER_W(PER_W)) u_pit (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .cnt_en  (cnt_en_q),
      .ivl     (ivl_q),
      .evt     (pit_evt)
   );

   always_comb begin
      stat = '0;
      for (int i = 0; i < NFLAG; i++) begin
         stat[FLAG_POS[i]] = flag_q[i];
         stat[EN_POS[i]]   = en_q[i];
      end
      stat[CNT_EN_POS] = cnt_en_q;
   end

   rtc_reg_rd #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .PER_W    (PER_W),
      .STAT_OFF (STAT_OFF),
      .PER_OFF  (PER_OFF),
      .RD_REG   (RD_REG)
   ) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .addr  (bus_addr),
      .stat  (stat),
      .ivl   (ivl_q),
      .rdata (bus_rdata)
   );

   assign irq_sec   = flag_q[SEC_IDX] & en_q[SEC_IDX];
   assign irq_alarm = |(flag_q & en_q & ALM_MASK);
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 8,
   parameter int                PER_W    = 10,
   parameter logic [ADDR_W-1:0] STAT_OFF = 8'h08
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              sec_tick,
   input logic              ms_tick,
   input logic [4:0]        alm_hit,
   input logic              irq_sec,
   input logic [6:0]        flag_q,
   input logic [6:0]        en_q,
   input logic              cnt_en_q,
   input logic              pit_evt,
   input logic [PER_W-1:0]  ivl_q
);
   logic st_wr;
   assign st_wr = bus_wr && (bus_addr == STAT_OFF);

   AST_SEC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> flag_q[1]); // R3
   AST_ALM1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[2] && !(st_wr && bus_wdata[4])) |=> flag_q[2]); // R3
   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && bus_wdata[4] && !alm_hit[1]) |=> !flag_q[2]); // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && bus_wdata[13] && pit_evt) |=> flag_q[6]); // R5
   AST_SEC_IRQ_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sec |-> (en_q[1] && flag_q[1])); // R6
   AST_PER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      pit_evt |-> (ms_tick && cnt_en_q)); // R8
   AST_ZERO_IVL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ivl_q == '0) |-> !pit_evt); // R9
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .PER_W    (PER_W),
   .STAT_OFF (STAT_OFF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .sec_tick  (sec_tick),
   .ms_tick   (ms_tick),
   .alm_hit   (alm_hit),
   .irq_sec   (irq_sec),
   .flag_q    (flag_q),
   .en_q      (en_q),
   .cnt_en_q  (cnt_en_q),
   .pit_evt   (pit_evt),
   .ivl_q     (ivl_q)
);

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_ST  = 8'h08;
   localparam logic [7:0] A_IVL = 8'h38;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [7:0]  addr;
      logic [15:0] wd;
      logic [4:0]  ev;
      logic        sec;
      logic [15:0] xrd;
      logic        xsec;
      logic        xalm;
   } vec_t;

   localparam int NVEC = 27;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0,1'b0,8'h00,16'h0000,5'h00,1'b1,16'h0000,1'b0,1'b0}, // R3 sec flag, R6 no irq
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0002,1'b0,1'b0}, // R2 R10
      '{1'b1,1'b0,A_ST ,16'h0008,5'h00,1'b0,16'h0000,1'b1,1'b0}, // R4 w0 keeps, R6
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h000A,1'b1,1'b0}, // R2
      '{1'b1,1'b0,A_ST ,16'h000A,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4 w1c
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0008,1'b0,1'b0}, // R4
      '{1'b0,1'b0,8'h00,16'h0000,5'h01,1'b0,16'h0000,1'b0,1'b0}, // R3 R7
      '{1'b1,1'b0,A_ST ,16'h000C,5'h00,1'b0,16'h0000,1'b0,1'b1}, // R7 pair 0/2
      '{1'b1,1'b0,A_ST ,16'h000D,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b0,1'b0,8'h00,16'h0000,5'h02,1'b0,16'h0000,1'b0,1'b0}, // R3 alarm 1
      '{1'b1,1'b0,A_ST ,16'h002C,5'h00,1'b0,16'h0000,1'b0,1'b1}, // R7 pair 4/5
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h003C,1'b0,1'b1}, // R2
      '{1'b1,1'b0,A_ST ,16'h003C,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b1,1'b0,A_ST ,16'h0C2C,5'h10,1'b0,16'h0000,1'b0,1'b1}, // R5 set wins
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0C2C,1'b0,1'b1}, // R5 R2
      '{1'b1,1'b0,A_ST ,16'h0C2C,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b0,1'b0,8'h00,16'h0000,5'h0C,1'b0,16'h0000,1'b0,1'b0}, // R3 R7
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h096C,1'b0,1'b0}, // R2
      '{1'b1,1'b0,A_ST ,16'h0000,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0140,1'b0,1'b0}, // R4 flags survive
      '{1'b1,1'b0,A_ST ,16'h0140,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R4
      '{1'b1,1'b0,A_IVL,16'h0003,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R2
      '{1'b0,1'b1,A_IVL,16'h0000,5'h00,1'b0,16'h0003,1'b0,1'b0}, // R2
      '{1'b1,1'b0,8'h10,16'hFFFF,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R2
      '{1'b0,1'b1,8'h10,16'h0000,5'h00,1'b0,16'h0000,1'b0,1'b0}, // R2
      '{1'b0,1'b1,A_ST ,16'h0000,5'h00,1'b0,16'h0000,1'b0,1'b0}  // R2 ignored write
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sec_tick = 1'b0, ms_tick = 1'b0;
   logic [4:0]  alm_hit = '0;
   logic        irq_sec, irq_alarm;
   int          nchk = 0, nfail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_irq_ctrl i_rtc_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sec_tick(sec_tick), .ms_tick(ms_tick), .alm_hit(alm_hit),
      .irq_sec(irq_sec), .irq_alarm(irq_alarm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] wd, input logic [4:0] ev,
                       input logic sec, input logic ms);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
      alm_hit = ev; sec_tick = sec; ms_tick = ms;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; alm_hit = '0; sec_tick = 1'b0; ms_tick = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] wd);
      step(1'b1, 1'b0, a, wd, 5'h00, 1'b0, 1'b0);
   endtask

   task automatic rd_reg(input logic [7:0] a);
      step(1'b0, 1'b1, a, 32'h0, 5'h00, 1'b0, 1'b0);
   endtask

   task automatic ms(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00, 32'h0, 5'h00, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq_sec in reset", {31'b0, irq_sec}, 32'h0);
      chk("R1 irq_alarm in reset", {31'b0, irq_alarm}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(A_ST);
      chk("R1 status after reset", bus_rdata, 32'h0);
      rd_reg(A_IVL);
      chk("R1 interval after reset", bus_rdata, 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         step(VECS[v].wr, VECS[v].rd, VECS[v].addr, {16'h0, VECS[v].wd},
              VECS[v].ev, VECS[v].sec, 1'b0);
         if (VECS[v].rd)
            chk($sformatf("R2/R10 vec %0d rdata", v), bus_rdata, {16'h0, VECS[v].xrd});
         chk($sformatf("R6 vec %0d irq_sec", v), {31'b0, irq_sec}, {31'b0, VECS[v].xsec});
         chk($sformatf("R7 vec %0d irq_alarm", v), {31'b0, irq_alarm}, {31'b0, VECS[v].xalm});
      end

      // R8 periodic with interval 3 (programmed by the table)
      wr_reg(A_ST, 32'hC000);
      ms(2);
      chk("R8 no event before third tick", {31'b0, irq_alarm}, 32'h0);
      ms(1);
      chk("R8 event on third tick", {31'b0, irq_alarm}, 32'h1);
      rd_reg(A_ST);
      chk("R8 periodic flag in status", bus_rdata, 32'hE000);
      wr_reg(A_ST, 32'hE000);
      chk("R4 periodic flag cleared", {31'b0, irq_alarm}, 32'h0);
      ms(2);
      chk("R8 restart no early event", {31'b0, irq_alarm}, 32'h0);
      ms(1);
      chk("R8 restart event after 3", {31'b0, irq_alarm}, 32'h1);
      wr_reg(A_ST, 32'h6000);
      ms(5);
      chk("R8 count enable off blocks", {31'b0, irq_alarm}, 32'h0);

      // R9 interval zero
      wr_reg(A_IVL, 32'h0);
      wr_reg(A_ST, 32'hC000);
      ms(5);
      chk("R9 zero interval quiet", {31'b0, irq_alarm}, 32'h0);

      // R5 periodic event coincides with clear write, interval 1
      wr_reg(A_IVL, 32'h1);
      step(1'b1, 1'b0, A_ST, 32'hE000, 5'h00, 1'b0, 1'b1);
      chk("R5 periodic set beats clear", {31'b0, irq_alarm}, 32'h1);
      rd_reg(A_ST);
      chk("R5 status shows flag", bus_rdata, 32'hE000);

      // R9 maximum interval 1000
      wr_reg(A_IVL, 32'd1000);
      wr_reg(A_ST, 32'hE000);
      ms(999);
      chk("R9 no event at 999 of 1000", {31'b0, irq_alarm}, 32'h0);
      ms(1);
      chk("R9 event at 1000", {31'b0, irq_alarm}, 32'h1);

      // R10 read data holds without a read strobe
      rd_reg(A_IVL);
      chk("R10 interval read", bus_rdata, 32'd1000);
      step(1'b0, 1'b0, A_ST, 32'h0, 5'h00, 1'b0, 1'b0);
      chk("R10 rdata holds", bus_rdata, 32'd1000);

      // R1 reset in the middle of activity
      step(1'b0, 1'b0, 8'h00, 32'h0, 5'h00, 1'b1, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 irq_alarm after mid reset", {31'b0, irq_alarm}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(A_ST);
      chk("R1 status after mid reset", bus_rdata, 32'h0);
      rd_reg(A_IVL);
      chk("R1 interval after mid reset", bus_rdata, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule